// File: doc/BRIEF.md
# Framing-Aware PRBS Test Pattern Generator

This block sits in a T1/E1 transmit path and replaces the outgoing serial data with a maximal-length pseudo-random bit sequence for diagnostics and production test. One of four sequence lengths is picked by a 2-bit select. An optional zero-run limiter can raise selected pattern zeros to ones so that long runs of zeros never reach the line. The limiter's threshold depends on whether a short or a long sequence is running.

A framed mode keeps the bit positions that the framer owns, and the generator holds its sequence over those positions instead of advancing. In T1 these are the single frame bits. In E1 they are time slot 0, plus time slot 16 when channel-associated signalling is in use. The framer supplies strobes that mark these positions. A level control starts and stops insertion. While stopped, the incoming data passes straight through. Each start, and each change of the select while running, loads the sequence register with all ones. Every line bit is qualified by a bit-clock enable, and the result is registered one clock later.

Top module: `prbsTestGen`

## Requirements
- R1: The select `patSel` 0,1,2,3 picks sequence length L = 11,15,20,23 with tap t = 9,14,17,18. With the limiter off, the n-th inserted bit after a reseed is 1 for n < L and otherwise a[n] = a[n-L] XOR a[n-t].
- R2: With `zeroLimEn` = 1 and `patSel` 0 or 1, no run of 8 consecutive zeros leaves among inserted bits. A pattern zero that would complete such a run is sent as 1, and the sequence itself advances unchanged.
- R3: With `zeroLimEn` = 1 and `patSel` 2 or 3, the same limit applies with a run length of 15. Select 2 with the limiter on gives the quasi-random signal.
- R4: In T1 framed mode (`framedEn` = 1, `e1Mode` = 0), a bit marked by `frameBitStb` carries `dataIn` unchanged, and the sequence does not advance on that bit.
- R5: In E1 framed mode, bits marked by `ts0Stb` carry `dataIn` and hold the sequence. Bits marked by `ts16Stb` do the same only when `casMode` = 1, and otherwise carry pattern.
- R6: With `framedEn` = 0, every bit carries pattern, whatever the position strobes say.
- R7: While `runCtl` = 0, each output bit equals the `dataIn` of its bit period.
- R8: The sequence register is loaded with all ones on the first running bit after a stop, and on a running bit whose `patSel` differs from that of the previous bit. As a result, the first inserted bit after either event is 1.
- R9: `dataOut` and `dataValid` update one clock after a cycle with `bitEn` = 1. After a cycle with `bitEn` = 0, `dataValid` is 0 and `dataOut` holds its value. Both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One line bit period per high cycle |
| patSel | input | 2 | Sequence length select |
| zeroLimEn | input | 1 | Enables the zero-run limiter |
| framedEn | input | 1 | Keeps framer-owned positions |
| e1Mode | input | 1 | 1 = E1 positions, 0 = T1 positions |
| casMode | input | 1 | E1 only: also keep time slot 16 |
| runCtl | input | 1 | 1 = insert pattern, 0 = pass through |
| frameBitStb | input | 1 | Marks a T1 frame bit |
| ts0Stb | input | 1 | Marks a bit of E1 time slot 0 |
| ts16Stb | input | 1 | Marks a bit of E1 time slot 16 |
| dataIn | input | 1 | Transmit data from the framer |
| dataOut | output | 1 | Transmit data toward the line |
| dataValid | output | 1 | High for the clock after each bit period |

## Verification
All four lengths are run long enough, with the limiter off, to compare against the recurrence. Any wrong tap or length then shows within a few dozen bits. The limiter runs are long enough for the short patterns to reach their natural longest zero runs: 10 zeros for length 11 and 14 for length 15. That distinguishes a threshold of 8 from 15 and shows that forcing a one does not disturb the sequence. Framed runs over full T1 and E1 frames, with signalling off and on, show whether the sequence pauses or skips at kept positions. The same strobes with framing off must be ignored. Random `dataIn`, idle bit periods, stops and select changes separate pass-through, hold and reseed behaviour.

// File: rtl/prbsTgPkg.sv
package prbsTgPkg;

  localparam int STATE_W = 23;
  localparam int NUM_PAT = 4;

  typedef struct packed {
    logic reseed;
    logic advance;
    logic stopped;
  } tgStrobe_t;

  function automatic int seqLen(input logic [1:0] sel);
    case (sel)
      2'd0:    return 11;
      2'd1:    return 15;
      2'd2:    return 20;
      default: return 23;
    endcase
  endfunction

  function automatic int seqTap(input logic [1:0] sel);
    case (sel)
      2'd0:    return 9;
      2'd1:    return 14;
      2'd2:    return 17;
      default: return 18;
    endcase
  endfunction

endpackage

// File: rtl/prbsTgControl.sv
module prbsTgControl
  import prbsTgPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       runCtl,
  input  logic [1:0] patSel,
  input  logic       framedEn,
  input  logic       e1Mode,
  input  logic       casMode,
  input  logic       frameBitStb,
  input  logic       ts0Stb,
  input  logic       ts16Stb,
  output tgStrobe_t  strobe
);

  logic       runQ;
  logic [1:0] selQ;
  logic       keepBit;
  logic       inserting;

  // positions owned by the framer in the current mode
  always_comb begin
    if (!framedEn)   keepBit = 1'b0;
    else if (e1Mode) keepBit = ts0Stb || (casMode && ts16Stb);
    else             keepBit = frameBitStb;
  end

  assign inserting = bitEn && runCtl;

  always_comb begin
    strobe.reseed  = inserting && (!runQ || (patSel != selQ));
    strobe.advance = inserting && !keepBit;
    strobe.stopped = bitEn && !runCtl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
      selQ <= 2'd0;
    end else if (bitEn) begin
      runQ <= runCtl;
      selQ <= patSel;
    end
  end

endmodule

// File: rtl/prbsTgDatapath.sv
module prbsTgDatapath
  import prbsTgPkg::*;
#(
  parameter int ZRUN_SHORT = 8,
  parameter int ZRUN_LONG  = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  tgStrobe_t  strobe,
  input  logic [1:0] patSel,
  input  logic       zeroLimEn,
  input  logic       dataIn,
  output logic       dataOut,
  output logic       dataValid
);

  localparam int CNT_W = $clog2(ZRUN_LONG + 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(ZRUN_SHORT - 1);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(ZRUN_LONG - 1);

  logic [STATE_W-1:0] lfsrState;
  logic [STATE_W-1:0] srcState;
  logic [STATE_W-1:0] candNext [NUM_PAT];
  logic               candOut  [NUM_PAT];
  logic [STATE_W-1:0] nextState;
  logic               patBit;
  logic               forceOne;
  logic               outBit;
  logic [CNT_W-1:0]   zeroCnt;
  logic [CNT_W-1:0]   zeroLim;

  assign srcState = strobe.reseed ? {STATE_W{1'b1}} : lfsrState;

  // one shift/feedback network per sequence length
  for (genvar g = 0; g < NUM_PAT; g++) begin : gPat
    localparam int LEN = seqLen(2'(g));
    localparam int TAP = seqTap(2'(g));
    logic fbBit;
    assign fbBit       = srcState[LEN-1] ^ srcState[TAP-1];
    assign candOut[g]  = srcState[LEN-1];
    assign candNext[g] = STATE_W'({srcState[LEN-2:0], fbBit});
  end

  assign patBit    = candOut[patSel];
  assign nextState = candNext[patSel];
  assign zeroLim   = patSel[1] ? LIM_LONG : LIM_SHORT;
  assign forceOne  = zeroLimEn && !patBit && (zeroCnt >= zeroLim);
  assign outBit    = patBit | forceOne;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsrState <= {STATE_W{1'b1}};
    end else if (strobe.advance) begin
      lfsrState <= nextState;
    end else if (strobe.reseed) begin
      lfsrState <= srcState;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroCnt <= '0;
    end else if (strobe.stopped) begin
      zeroCnt <= '0;
    end else if (strobe.advance) begin
      if (outBit)                 zeroCnt <= '0;
      else if (zeroCnt != CNT_MAX) zeroCnt <= zeroCnt + 1'b1;
    end else if (strobe.reseed) begin
      zeroCnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut   <= 1'b0;
      dataValid <= 1'b0;
    end else begin
      dataValid <= bitEn;
      if (bitEn) dataOut <= strobe.advance ? outBit : dataIn;
    end
  end

endmodule

// File: rtl/prbsTestGen.sv
module prbsTestGen
  import prbsTgPkg::*;
#(
  parameter int ZRUN_SHORT = 8,
  parameter int ZRUN_LONG  = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic [1:0] patSel,
  input  logic       zeroLimEn,
  input  logic       framedEn,
  input  logic       e1Mode,
  input  logic       casMode,
  input  logic       runCtl,
  input  logic       frameBitStb,
  input  logic       ts0Stb,
  input  logic       ts16Stb,
  input  logic       dataIn,
  output logic       dataOut,
  output logic       dataValid
);

  tgStrobe_t strobe;

  prbsTgControl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .runCtl     (runCtl),
    .patSel     (patSel),
    .framedEn   (framedEn),
    .e1Mode     (e1Mode),
    .casMode    (casMode),
    .frameBitStb(frameBitStb),
    .ts0Stb     (ts0Stb),
    .ts16Stb    (ts16Stb),
    .strobe     (strobe)
  );

  prbsTgDatapath #(
    .ZRUN_SHORT(ZRUN_SHORT),
    .ZRUN_LONG (ZRUN_LONG)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .bitEn    (bitEn),
    .strobe   (strobe),
    .patSel   (patSel),
    .zeroLimEn(zeroLimEn),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataValid(dataValid)
  );

endmodule

// File: rtl/prbsTestGenChecker.sv
module prbsTestGenChecker #(
  parameter int ZRUN_SHORT = 8,
  parameter int ZRUN_LONG  = 15
) (
  input logic       clk,
  input logic       rstN,
  input logic       bitEn,
  input logic [1:0] patSel,
  input logic       zeroLimEn,
  input logic       framedEn,
  input logic       e1Mode,
  input logic       casMode,
  input logic       runCtl,
  input logic       frameBitStb,
  input logic       ts0Stb,
  input logic       ts16Stb,
  input logic       dataIn,
  input logic       dataOut,
  input logic       dataValid
);

  logic       keepNow;
  logic       prevRun;
  logic [1:0] prevSel;
  logic       lastLimIns;
  logic       lastLong;
  logic       lastClear;
  logic       lastSeedBit;
  int         zrun;

  assign keepNow = framedEn && (e1Mode ? (ts0Stb || (casMode && ts16Stb)) : frameBitStb);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRun     <= 1'b0;
      prevSel     <= 2'd0;
      lastLimIns  <= 1'b0;
      lastLong    <= 1'b0;
      lastClear   <= 1'b0;
      lastSeedBit <= 1'b0;
      zrun        <= 0;
    end else begin
      if (bitEn) begin
        prevRun <= runCtl;
        prevSel <= patSel;
      end
      lastLimIns  <= bitEn && runCtl && !keepNow && zeroLimEn;
      lastLong    <= patSel[1];
      lastClear   <= bitEn && (!runCtl || !zeroLimEn);
      lastSeedBit <= bitEn && runCtl && !keepNow && (!prevRun || patSel != prevSel);
      if (dataValid) begin
        if (lastClear)       zrun <= 0;
        else if (lastLimIns) zrun <= dataOut ? 0 : zrun + 1;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    bitEn |=> dataValid); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> (!dataValid && $stable(dataOut))); // R9

  AST_STOP_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && !runCtl) |=> (dataOut == $past(dataIn))); // R7

  AST_T1_FRAME_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && runCtl && framedEn && !e1Mode && frameBitStb) |=> (dataOut == $past(dataIn))); // R4

  AST_E1_SLOT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && runCtl && framedEn && e1Mode && (ts0Stb || (casMode && ts16Stb)))
      |=> (dataOut == $past(dataIn))); // R5

  AST_SEED_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && lastSeedBit) |-> dataOut); // R8

  AST_ZRUN_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && lastLimIns && !lastLong && !dataOut) |-> (zrun + 1 < ZRUN_SHORT)); // R2

  AST_ZRUN_LONG: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && lastLimIns && lastLong && !dataOut) |-> (zrun + 1 < ZRUN_LONG)); // R3

endmodule

bind prbsTestGen prbsTestGenChecker #(
  .ZRUN_SHORT(ZRUN_SHORT),
  .ZRUN_LONG (ZRUN_LONG)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .bitEn      (bitEn),
  .patSel     (patSel),
  .zeroLimEn  (zeroLimEn),
  .framedEn   (framedEn),
  .e1Mode     (e1Mode),
  .casMode    (casMode),
  .runCtl     (runCtl),
  .frameBitStb(frameBitStb),
  .ts0Stb     (ts0Stb),
  .ts16Stb    (ts16Stb),
  .dataIn     (dataIn),
  .dataOut    (dataOut),
  .dataValid  (dataValid)
);

// File: tb/prbsTestGen_test.sv
`timescale 1ns/1ps
module prbsTestGen_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic [1:0] patSel = 2'd0;
  logic       zeroLimEn = 1'b0;
  logic       framedEn = 1'b0;
  logic       e1Mode = 1'b0;
  logic       casMode = 1'b0;
  logic       runCtl = 1'b0;
  logic       frameBitStb = 1'b0;
  logic       ts0Stb = 1'b0;
  logic       ts16Stb = 1'b0;
  logic       dataIn = 1'b0;
  logic       dataOut;
  logic       dataValid;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  // reference model state
  bit        mRunQ = 1'b0;
  bit [1:0]  mSelQ = 2'd0;
  int        mK = 0;
  bit [31:0] hist = '0;
  int        mZc = 0;
  bit        pending = 1'b0;
  bit        expOut = 1'b0;
  bit        expValid = 1'b0;
  string     expTag = "";

  always #2 clk = ~clk;

  prbsTestGen uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .patSel(patSel),
    .zeroLimEn(zeroLimEn), .framedEn(framedEn), .e1Mode(e1Mode),
    .casMode(casMode), .runCtl(runCtl), .frameBitStb(frameBitStb),
    .ts0Stb(ts0Stb), .ts16Stb(ts16Stb), .dataIn(dataIn),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  task automatic report(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkPending();
    if (pending) begin
      report({expTag, " data"}, dataOut, expOut);
      report("R9 valid", dataValid, expValid);
    end
  endtask

  task automatic doBit(input bit run, input bit [1:0] sel, input bit zl,
                       input bit fr, input bit e1, input bit cas,
                       input bit fb, input bit t0, input bit t16,
                       input string tag);
    bit keep, din, p, o;
    int len, tap, thr;
    @(negedge clk);
    checkPending();
    din = 1'($urandom);
    bitEn = 1'b1; runCtl = run; patSel = sel; zeroLimEn = zl;
    framedEn = fr; e1Mode = e1; casMode = cas;
    frameBitStb = fb; ts0Stb = t0; ts16Stb = t16; dataIn = din;
    keep = fr && (e1 ? (t0 || (cas && t16)) : fb);
    if (!run) begin
      expOut = din;
      mZc = 0;
    end else begin
      if (!mRunQ || sel != mSelQ) begin
        mK = 0;
        mZc = 0;
      end
      if (keep) begin
        expOut = din;
      end else begin
        len = 11 + 4 * int'(sel == 2'd1) + 9 * int'(sel == 2'd2) + 12 * int'(sel == 2'd3);
        tap = len - 2 - int'(sel == 2'd1) - int'(sel == 2'd3) * 3 + int'(sel == 2'd1) * 2;
        if (sel == 2'd2) tap = 17;
        if (sel == 2'd3) tap = 18;
        if (sel == 2'd1) tap = 14;
        if (sel == 2'd0) tap = 9;
        p = (mK < len) ? 1'b1 : (hist[len-1] ^ hist[tap-1]);
        hist = {hist[30:0], p};
        mK++;
        thr = sel[1] ? 15 : 8;
        o = p | (zl && !p && (mZc >= thr - 1));
        mZc = o ? 0 : mZc + 1;
        if (zl && mZc >= thr) report({tag, " zero run"}, mZc, thr - 1);
        expOut = o;
      end
    end
    mRunQ = run;
    mSelQ = sel;
    expValid = 1'b1;
    expTag = tag;
    pending = 1'b1;
  endtask

  task automatic doIdle(input bit [1:0] sel);
    @(negedge clk);
    checkPending();
    bitEn = 1'b0;
    patSel = sel;
    runCtl = ~runCtl;
    dataIn = ~dataIn;
    expValid = 1'b0;
    expTag = "R9 idle";
    pending = 1'b1;
    @(negedge clk);
    checkPending();
    runCtl = ~runCtl;
    pending = 1'b0;
  endtask

  // kind: 0 no strobes, 1 T1 frame bit every 193, 2 E1 slots in 256-bit frames
  task automatic phase(input int nBits, input bit run, input bit [1:0] sel,
                       input bit zl, input bit fr, input bit e1, input bit cas,
                       input int kind, input string tag);
    for (int i = 0; i < nBits; i++) begin
      bit fb, t0, t16;
      fb  = (kind == 1) && (i % 193 == 0);
      t0  = (kind == 2) && (i % 256 < 8);
      t16 = (kind == 2) && (i % 256 >= 128) && (i % 256 < 136);
      doBit(run, sel, zl, fr, e1, cas, fb, t0, t16, tag);
      if (i % 701 == 350) doIdle(sel);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    report("R9 reset dataOut", dataOut, 0);
    report("R9 reset dataValid", dataValid, 0);
    rstN = 1'b1;

    phase(60, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R7");
    phase(2200, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R1 R8");
    phase(2200, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R2");
    phase(33000, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R2 R8");
    phase(4000, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R1");
    phase(12000, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R3");
    phase(4000, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R1");
    phase(12000, 1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R3");
    phase(4000, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R1");
    phase(30, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R7");
    phase(193 * 40, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1, "R4");
    phase(256 * 20, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 2, "R5");
    phase(256 * 20, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 2, "R5");
    phase(256 * 6, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2, "R6");
    phase(193 * 6, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1, "R6");
    phase(40, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1, "R7");
    phase(500, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1, "R8");

    @(negedge clk);
    checkPending();
    pending = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule